// File: doc/BRIEF.md
# Smart Card Status and Interrupt Controller

This block keeps the status flags of a serial smart card link and turns them into three masked request lines: transmit-ready, receive-full and link error. The transmit and receive bit engines feed it one-cycle event pulses: a frame finished, a byte arrived, a parity, overrun or framing/error-signal problem was seen. A level input marks an automatic retransmission in progress. A DMA controller acknowledges transfers, and the CPU reads the status word, clears flags and sets two enable bits.

Transfers through DMA need no CPU help. An acknowledge clears the matching data flag by itself. A retransmission after an error keeps the transmit-ready flag low, so no new request goes out for a byte that is still being resent. Error flags are sticky and only a software clear removes them. Software clears a flag in two steps: it reads the flag as 1, then writes 0 to that bit. All request outputs are registered. There is no streamed data path: every pin is a plain control or status strobe, so no valid/ready back-pressure applies.

Top module: `sc_stat_irq`

## Requirements
- R1: After reset, status bit 0 (transmit-end) is 1 and every other status bit is 0. Both enables are 0 and every request output is 0. Status layout: bit0 transmit-end, bit1 receive-full, bit2 overrun, bit3 parity error, bit4 framing/error-signal.
- R2: `irq_txe_o` is 1 one cycle after status bit0 is 1 while the transmit enable is 1, and is 0 otherwise.
- R3: `irq_rxf_o` is 1 one cycle after status bit1 is 1 while the receive enable is 1, and is 0 otherwise.
- R4: `irq_err_o` is 1 one cycle after any of status bits 2..4 is 1 while the receive enable is 1. No other mask gates it.
- R5: `irq_tend_o` is always 0.
- R6: A transmit DMA acknowledge clears bit0 and a receive DMA acknowledge clears bit1, with no software action.
- R7: While `retx_active_i` is 1, bit0 is forced to 0 and frame-done pulses do not set it.
- R8: A byte-received pulse in the same cycle as any receive error sets the error bit and leaves bit1 unset.
- R9: Error bits 2..4 are not cleared by DMA acknowledges, by retransmission or by later events. Only the software clear removes them.
- R10: A write of 0 to a status bit clears it only if a read since the bit was last set returned it as 1. A write of 0 with no such read has no effect. Writing 1 never sets a bit.
- R11: When a set event and a clear (software or DMA) reach one bit in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_frame_done_i | input | 1 | Pulse: a transmit frame finished |
| rx_byte_done_i | input | 1 | Pulse: a receive byte finished |
| rx_parity_err_i | input | 1 | Pulse: parity error on receive |
| rx_overrun_i | input | 1 | Pulse: receive overrun |
| line_err_i | input | 1 | Pulse: framing error or error signal seen |
| retx_active_i | input | 1 | Level: automatic retransmission in progress |
| dma_tx_ack_i | input | 1 | Pulse: DMA wrote a transmit byte |
| dma_rx_ack_i | input | 1 | Pulse: DMA read a receive byte |
| stat_rd_i | input | 1 | Strobe: CPU reads the status word |
| stat_wr_i | input | 1 | Strobe: CPU writes the status word |
| stat_wdata_i | input | 5 | Status write data (0 requests a clear) |
| ctl_wr_i | input | 1 | Strobe: CPU writes the enables |
| ctl_tx_ie_i | input | 1 | Transmit request enable value |
| ctl_rx_ie_i | input | 1 | Receive and error request enable value |
| stat_o | output | 5 | Status word |
| irq_txe_o | output | 1 | Transmit-ready request |
| irq_rxf_o | output | 1 | Receive-full request |
| irq_err_o | output | 1 | Error request |
| irq_tend_o | output | 1 | Transmit-end request, held at 0 |

## Verification
The assertions check, on every cycle: a set event leaves its flag at 1, no flag falls without an armed clear or a hardware clear, retransmission keeps the transmit-end flag at 0, DMA acknowledges clear the data flags, and error flags survive anything but a software write. The bench sweeps every combination of the five event pulses against all four enable settings and compares the status word and the requests with values it computes itself. Only its scenarios show the two-step clear order, the ignored write of 1, and the exact cycle at which each request follows its flag.

// File: rtl/sc_stat_pkg.sv
package sc_stat_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int B_TEND    = 0;
  localparam int B_RXF     = 1;
  localparam int B_OVR     = 2;
  localparam int B_PAR     = 3;
  localparam int B_FER     = 4;
  localparam int NUM_ERR   = NUM_FLAGS - B_OVR;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  localparam flag_vec_t FLAG_RST = flag_vec_t'(1) << B_TEND;
  localparam flag_vec_t ERR_MASK = ((flag_vec_t'(1) << NUM_ERR) - 1) << B_OVR;
endpackage

// File: rtl/sc_flag_cell.sv
module sc_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic sw_clr;

  always_comb begin
    sw_clr = wr_i & ~wbit_i & arm_q;
    flag_d = set_i | (flag_q & ~(sw_clr | hw_clr_i));
    if (!flag_d || set_i)
      arm_d = 1'b0;
    else if (rd_i && flag_q)
      arm_d = 1'b1;
    else
      arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R11: a set event always leaves the flag at 1
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R10: without an armed clear or a hardware clear the flag never falls
  a_r10_no_unarmed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q && !hw_clr_i) |=> (flag_q || !$past(flag_q)));
endmodule

// File: rtl/sc_evt_map.sv
module sc_evt_map
  import sc_stat_pkg::*;
(
  input  logic      tx_frame_done_i,
  input  logic      rx_byte_done_i,
  input  logic      rx_parity_err_i,
  input  logic      rx_overrun_i,
  input  logic      line_err_i,
  input  logic      retx_active_i,
  input  logic      dma_tx_ack_i,
  input  logic      dma_rx_ack_i,
  output flag_vec_t set_o,
  output flag_vec_t hw_clr_o
);
  logic rx_bad;

  always_comb begin
    rx_bad = rx_parity_err_i | rx_overrun_i | line_err_i;
    set_o  = '0;
    set_o[B_TEND] = tx_frame_done_i & ~retx_active_i;
    set_o[B_RXF]  = rx_byte_done_i & ~rx_bad;
    set_o[B_OVR]  = rx_overrun_i;
    set_o[B_PAR]  = rx_parity_err_i;
    set_o[B_FER]  = line_err_i;

    hw_clr_o = '0;
    hw_clr_o[B_TEND] = dma_tx_ack_i | retx_active_i;
    hw_clr_o[B_RXF]  = dma_rx_ack_i;
  end
endmodule

// File: rtl/sc_req_gen.sv
module sc_req_gen
  import sc_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags_i,
  input  logic      ctl_wr_i,
  input  logic      ctl_tx_ie_i,
  input  logic      ctl_rx_ie_i,
  output logic      irq_txe_o,
  output logic      irq_rxf_o,
  output logic      irq_err_o
);
  logic tie_q, rie_q;
  logic txe_q, rxf_q, err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tie_q <= 1'b0;
      rie_q <= 1'b0;
      txe_q <= 1'b0;
      rxf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ctl_wr_i) begin
        tie_q <= ctl_tx_ie_i;
        rie_q <= ctl_rx_ie_i;
      end
      txe_q <= flags_i[B_TEND] & tie_q;
      rxf_q <= flags_i[B_RXF] & rie_q;
      err_q <= (|(flags_i & ERR_MASK)) & rie_q;
    end
  end

  assign irq_txe_o = txe_q;
  assign irq_rxf_o = rxf_q;
  assign irq_err_o = err_q;

  // R4: an error request always traces back to an error flag
  a_r4_err_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o |-> $past(|(flags_i & ERR_MASK)));

  // R2: a transmit request never appears without a transmit-end flag
  a_r2_txe_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txe_o |-> $past(flags_i[B_TEND]));
endmodule

// File: rtl/sc_stat_irq.sv
module sc_stat_irq
  import sc_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_frame_done_i,
  input  logic                 rx_byte_done_i,
  input  logic                 rx_parity_err_i,
  input  logic                 rx_overrun_i,
  input  logic                 line_err_i,
  input  logic                 retx_active_i,
  input  logic                 dma_tx_ack_i,
  input  logic                 dma_rx_ack_i,
  input  logic                 stat_rd_i,
  input  logic                 stat_wr_i,
  input  logic [NUM_FLAGS-1:0] stat_wdata_i,
  input  logic                 ctl_wr_i,
  input  logic                 ctl_tx_ie_i,
  input  logic                 ctl_rx_ie_i,
  output logic [NUM_FLAGS-1:0] stat_o,
  output logic                 irq_txe_o,
  output logic                 irq_rxf_o,
  output logic                 irq_err_o,
  output logic                 irq_tend_o
);
  flag_vec_t set_v, hw_clr_v, flags;

  sc_evt_map u_map (
    .tx_frame_done_i (tx_frame_done_i),
    .rx_byte_done_i  (rx_byte_done_i),
    .rx_parity_err_i (rx_parity_err_i),
    .rx_overrun_i    (rx_overrun_i),
    .line_err_i      (line_err_i),
    .retx_active_i   (retx_active_i),
    .dma_tx_ack_i    (dma_tx_ack_i),
    .dma_rx_ack_i    (dma_rx_ack_i),
    .set_o           (set_v),
    .hw_clr_o        (hw_clr_v)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sc_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_v[i]),
      .hw_clr_i (hw_clr_v[i]),
      .rd_i     (stat_rd_i),
      .wr_i     (stat_wr_i),
      .wbit_i   (stat_wdata_i[i]),
      .flag_o   (flags[i])
    );
  end

  sc_req_gen u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags_i     (flags),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_tx_ie_i (ctl_tx_ie_i),
    .ctl_rx_ie_i (ctl_rx_ie_i),
    .irq_txe_o   (irq_txe_o),
    .irq_rxf_o   (irq_rxf_o),
    .irq_err_o   (irq_err_o)
  );

  assign stat_o     = flags;
  assign irq_tend_o = 1'b0;

  // R7: retransmission keeps the transmit-end flag low
  a_r7_retx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    retx_active_i |=> !stat_o[B_TEND]);

  // R8: a byte arriving with an error never raises receive-full
  a_r8_err_blocks_rxf: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_done_i && (rx_parity_err_i || rx_overrun_i || line_err_i)
     && !stat_o[B_RXF] && !dma_rx_ack_i) |=> !stat_o[B_RXF]);

  // R6: a receive DMA acknowledge without a new byte clears receive-full
  a_r6_dma_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_ack_i && !rx_byte_done_i) |=> !stat_o[B_RXF]);

  // R6: a transmit DMA acknowledge without a new frame clears transmit-end
  a_r6_dma_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_ack_i && !tx_frame_done_i) |=> !stat_o[B_TEND]);

  // R9: error flags never fall without a software write
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_i |=> (($past(stat_o) & ERR_MASK & ~stat_o) == '0));
endmodule

// File: tb/sc_stat_irq_test.sv
module sc_stat_irq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_done = 0, rx_done = 0, par = 0, ovr = 0, ferr = 0, retx = 0;
  logic dtx = 0, drx = 0, rd = 0, wr = 0, cwr = 0, tie = 0, rie = 0;
  logic [4:0] wdata = '0;
  logic [4:0] stat;
  logic irq_txe, irq_rxf, irq_err, irq_tend;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sc_stat_irq uut (
    .clk(clk), .rst_n(rst_n),
    .tx_frame_done_i(tx_done), .rx_byte_done_i(rx_done),
    .rx_parity_err_i(par), .rx_overrun_i(ovr), .line_err_i(ferr),
    .retx_active_i(retx), .dma_tx_ack_i(dtx), .dma_rx_ack_i(drx),
    .stat_rd_i(rd), .stat_wr_i(wr), .stat_wdata_i(wdata),
    .ctl_wr_i(cwr), .ctl_tx_ie_i(tie), .ctl_rx_ie_i(rie),
    .stat_o(stat), .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf),
    .irq_err_o(irq_err), .irq_tend_o(irq_tend)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_en(input logic t, input logic r);
    cwr = 1; tie = t; rie = r; tick(); cwr = 0;
  endtask

  task automatic clear_all();
    rd = 1; tick(); rd = 0;
    wr = 1; wdata = '0; tick(); wr = 0; wdata = '0;
  endtask

  task automatic pulse(input logic [4:0] ev);
    {ferr, par, ovr, rx_done, tx_done} = ev;
    tick();
    {ferr, par, ovr, rx_done, tx_done} = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp_s;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 status", stat, 5'b00001);
    check("R1 txe", irq_txe, 0);
    check("R1 rxf", irq_rxf, 0);
    check("R1 err", irq_err, 0);

    // R2: reset transmit-end flag reaches request one cycle after enable
    set_en(1, 1);
    check("R2 txe before", irq_txe, 0);
    tick();
    check("R2 txe after", irq_txe, 1);
    check("R5 tend", irq_tend, 0);

    // Sweep all event combinations against all enables (R2 R3 R4 R8 R5)
    for (int v = 0; v < 32; v++) begin
      for (int en = 0; en < 4; en++) begin
        clear_all();
        set_en(en[0], en[1]);
        pulse(v[4:0]);
        exp_s[0] = v[0];
        exp_s[1] = v[1] & ~(v[2] | v[3] | v[4]);
        exp_s[4:2] = v[4:2];
        check("R8 status sweep", stat, exp_s);
        tick();
        check("R2 txe sweep", irq_txe, exp_s[0] & en[0]);
        check("R3 rxf sweep", irq_rxf, exp_s[1] & en[1]);
        check("R4 err sweep", irq_err, (|exp_s[4:2]) & en[1]);
        check("R5 tend sweep", irq_tend, 0);
      end
    end

    // R10: two-step clear
    clear_all();
    check("R10 clear all", stat, 0);
    pulse(5'b01000);
    wr = 1; wdata = 5'b00000; tick(); wr = 0;
    check("R10 unarmed write 0", stat, 5'b01000);
    rd = 1; tick(); rd = 0;
    wr = 1; wdata = 5'b11111; tick(); wr = 0;
    check("R10 write 1", stat, 5'b01000);
    wr = 1; wdata = 5'b10111; tick(); wr = 0;
    check("R10 armed write 0", stat, 5'b00000);
    wr = 1; wdata = 5'b11111; tick(); wr = 0;
    check("R10 write 1 no set", stat, 5'b00000);

    // R6 and R9: DMA clears data flags only
    pulse(5'b10011);
    check("R6 setup", stat, 5'b10001);
    dtx = 1; tick(); dtx = 0;
    check("R6 tx ack", stat, 5'b10000);
    pulse(5'b00010);
    drx = 1; tick(); drx = 0;
    check("R6 rx ack", stat, 5'b10000);
    dtx = 1; drx = 1; retx = 1; tick(); dtx = 0; drx = 0; retx = 0;
    check("R9 error kept", stat, 5'b10000);

    // R7: retransmission holds transmit-end low
    clear_all();
    set_en(1, 0);
    pulse(5'b00001);
    check("R7 setup", stat, 5'b00001);
    retx = 1; tx_done = 1; tick(); tx_done = 0;
    check("R7 forced low", stat, 5'b00000);
    tick();
    check("R7 done ignored", stat, 5'b00000);
    check("R7 no txe", irq_txe, 0);
    retx = 0;
    pulse(5'b00001);
    check("R7 after retx", stat, 5'b00001);

    // R11: set wins over clears
    clear_all();
    pulse(5'b00010);
    rd = 1; tick(); rd = 0;
    wr = 1; wdata = 5'b00000; rx_done = 1; tick(); wr = 0; rx_done = 0;
    check("R11 sw clear vs set", stat[1], 1);
    drx = 1; rx_done = 1; tick(); drx = 0; rx_done = 0;
    check("R11 dma vs set", stat[1], 1);
    dtx = 1; tx_done = 1; tick(); dtx = 0; tx_done = 0;
    check("R11 dma tx vs set", stat[0], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule